// File: doc/BRIEF.md
# Asynchronous Frame Format Decoder and Bit-Rate Generator

This block sits beside the register file of a two-wire serial controller. Software programs four byte-wide mode registers through write strobes: a line-mode byte, a character-format byte, and the low and high bytes of a 16-bit time constant. The block holds those bytes and decodes the parity, stop-bit and character-length settings for the serializer. From its own reference clock it also produces a one-cycle bit-rate tick.

The tick comes from two counters in series. A reloadable divider fires once every time-constant-plus-two reference cycles. A prescaler then passes one of every 1, 16, 32 or 64 of those pulses, as the line-mode byte selects. A write to any byte that affects timing restarts both counters. The serializer that consumes the tick is a separate block.

Top module: `async_fmt_baud`

## Requirements
- R1: After reset the line-mode byte is 0x04 and the other three bytes are 0. The outputs read no parity, one stop bit and 5-bit characters, and `baud_tick` pulses every 2 cycles.
- R2: `par_en` equals bit 0 of the line-mode byte. `par_even` equals bit 1 of that byte (1 means even, 0 means odd).
- R3: `two_stop` is 1 exactly when bits 3:2 of the line-mode byte are 11. Every other value gives one stop bit.
- R4: Bits 6:5 of the character-format byte set `char_bits`: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8. `char_bits` is always in the range 5 to 8.
- R5: In x1 mode the tick period is TC+2 cycles. TC is {high byte, low byte}.
- R6: Bits 7:6 of the line-mode byte multiply the period: 00 by 1, 01 by 16, 10 by 32, 11 by 64.
- R7: A write to the line-mode byte or to either time-constant byte restarts timing. `baud_tick` is low in the cycle after that write edge. The first tick is high in the cycle after the edge that falls (TC+2)×prescale edges after the write edge.
- R8: `baud_tick` is never high for two cycles in a row.
- R9: A write to the character-format byte leaves the tick phase undisturbed.
- R10: Decoded format outputs take their new values in the cycle right after the write edge. They hold while no write to their byte occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_we | input | 1 | Write strobe for the line-mode byte |
| frame_we | input | 1 | Write strobe for the character-format byte |
| tc_lo_we | input | 1 | Write strobe for the time-constant low byte |
| tc_hi_we | input | 1 | Write strobe for the time-constant high byte |
| wr_data | input | 8 | Write data shared by all strobes |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Parity sense, 1 = even |
| two_stop | output | 1 | Two stop bits selected |
| char_bits | output | 4 | Character length, 5 to 8 |
| baud_tick | output | 1 | One-cycle bit-rate pulse |

## Verification
Decoded format fields are due in the cycle right after the write edge, so the bench samples them at the next falling edge. The tick passes through one output register, so its first pulse after a timing write is sampled at the falling edge that follows edge number (TC+2)×prescale. A bench cycle counter, incremented on rising edges, measures that distance and the gap to the next pulse, and compares them with a period computed by a bench function. For the character-format write, the distance is still counted from the earlier timing write.

// File: rtl/async_fmt_baud_pkg.sv
package async_fmt_baud_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TC_W   = 16;
  localparam int unsigned PRE_W  = 6;

  // line-mode byte field positions
  localparam int unsigned PAR_EN_BIT   = 0;
  localparam int unsigned PAR_EVEN_BIT = 1;
  localparam int unsigned STOP_LO      = 2;
  localparam int unsigned CMODE_LO     = 6;
  // character-format byte field position
  localparam int unsigned LEN_LO       = 5;

  localparam logic [BYTE_W-1:0] MODE_RST = 8'h04;

  typedef enum logic [1:0] {
    CM_X1  = 2'b00,
    CM_X16 = 2'b01,
    CM_X32 = 2'b10,
    CM_X64 = 2'b11
  } clk_mode_e;

  // non-monotonic length code
  function automatic logic [3:0] len_decode(input logic [1:0] code);
    case (code)
      2'b00:   len_decode = 4'd5;
      2'b01:   len_decode = 4'd7;
      2'b10:   len_decode = 4'd6;
      default: len_decode = 4'd8;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] pre_last(input clk_mode_e m);
    case (m)
      CM_X1:   pre_last = PRE_W'(0);
      CM_X16:  pre_last = PRE_W'(15);
      CM_X32:  pre_last = PRE_W'(31);
      default: pre_last = PRE_W'(63);
    endcase
  endfunction

endpackage

// File: rtl/afb_cfg_regs.sv
module afb_cfg_regs
  import async_fmt_baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              frame_we,
  input  logic              tc_lo_we,
  input  logic              tc_hi_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] frame_q,
  output logic [TC_W-1:0]   tc_q,
  output logic              restart
);

  logic [BYTE_W-1:0] mode_d, frame_d;
  logic [TC_W-1:0]   tc_d;

  always_comb begin
    mode_d  = mode_q;
    frame_d = frame_q;
    tc_d    = tc_q;
    if (mode_we)  mode_d  = wr_data;
    if (frame_we) frame_d = wr_data;
    if (tc_lo_we) tc_d[BYTE_W-1:0] = wr_data;
    if (tc_hi_we) tc_d[TC_W-1:BYTE_W] = wr_data;
  end

  assign restart = mode_we | tc_lo_we | tc_hi_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      frame_q <= '0;
      tc_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      frame_q <= frame_d;
      tc_q    <= tc_d;
    end
  end

endmodule

// File: rtl/afb_fmt_decode.sv
module afb_fmt_decode
  import async_fmt_baud_pkg::*;
(
  input  logic [BYTE_W-1:0] mode_q,
  input  logic [BYTE_W-1:0] frame_q,
  output logic              par_en,
  output logic              par_even,
  output logic              two_stop,
  output logic [3:0]        char_bits,
  output clk_mode_e         cmode
);

  always_comb begin
    par_en    = mode_q[PAR_EN_BIT];
    par_even  = mode_q[PAR_EVEN_BIT];
    two_stop  = (mode_q[STOP_LO+1:STOP_LO] == 2'b11);
    char_bits = len_decode(frame_q[LEN_LO+1:LEN_LO]);
    cmode     = clk_mode_e'(mode_q[CMODE_LO+1:CMODE_LO]);
  end

endmodule

// File: rtl/afb_divider.sv
module afb_divider
  import async_fmt_baud_pkg::*;
#(
  parameter int unsigned W = TC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tc,
  input  logic         restart,
  output logic         hit
);

  localparam int unsigned CW = W + 1;

  logic [CW-1:0] cnt_q, cnt_d, last;

  assign last = {1'b0, tc} + CW'(1);
  assign hit  = (cnt_q == last);

  always_comb begin
    if (restart || hit) cnt_d = '0;
    else                cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/afb_prescaler.sv
module afb_prescaler
  import async_fmt_baud_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  clk_mode_e cmode,
  input  logic      restart,
  output logic      tick
);

  logic [PRE_W-1:0] pre_q, pre_d, plast;
  logic             pass, tick_d;

  assign plast = pre_last(cmode);
  assign pass  = hit && (pre_q == plast);

  always_comb begin
    pre_d  = pre_q;
    tick_d = 1'b0;
    if (restart) begin
      pre_d = '0;
    end else if (hit) begin
      pre_d  = pass ? '0 : pre_q + PRE_W'(1);
      tick_d = pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tick  <= 1'b0;
    end else begin
      pre_q <= pre_d;
      tick  <= tick_d;
    end
  end

endmodule

// File: rtl/async_fmt_baud.sv
module async_fmt_baud
  import async_fmt_baud_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       frame_we,
  input  logic       tc_lo_we,
  input  logic       tc_hi_we,
  input  logic [7:0] wr_data,
  output logic       par_en,
  output logic       par_even,
  output logic       two_stop,
  output logic [3:0] char_bits,
  output logic       baud_tick
);

  logic              rst_meta, rst_sync_n;
  logic [BYTE_W-1:0] mode_q, frame_q;
  logic [TC_W-1:0]   tc_q;
  logic              restart, hit;
  clk_mode_e         cmode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  afb_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .mode_we(mode_we), .frame_we(frame_we),
    .tc_lo_we(tc_lo_we), .tc_hi_we(tc_hi_we),
    .wr_data(wr_data),
    .mode_q(mode_q), .frame_q(frame_q), .tc_q(tc_q), .restart(restart)
  );

  afb_fmt_decode u_dec (
    .mode_q(mode_q), .frame_q(frame_q),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .char_bits(char_bits), .cmode(cmode)
  );

  afb_divider #(.W(TC_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .tc(tc_q), .restart(restart), .hit(hit)
  );

  afb_prescaler u_pre (
    .clk(clk), .rst_n(rst_sync_n), .hit(hit), .cmode(cmode),
    .restart(restart), .tick(baud_tick)
  );

endmodule

// File: rtl/async_fmt_baud_chk.sv
module async_fmt_baud_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_we,
  input logic       frame_we,
  input logic       tc_lo_we,
  input logic       tc_hi_we,
  input logic [7:0] wr_data,
  input logic       par_en,
  input logic       par_even,
  input logic       two_stop,
  input logic [3:0] char_bits,
  input logic       baud_tick
);

  AST_PAR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (par_en == $past(wr_data[0]) && par_even == $past(wr_data[1]))); // R2

  AST_STOP_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (two_stop == ($past(wr_data[3:2]) == 2'b11))); // R3

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_bits >= 4'd5 && char_bits <= 4'd8)); // R4

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we || tc_lo_we || tc_hi_we) |=> !baud_tick); // R7

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick); // R8

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_we && !frame_we) |=> ($stable(par_en) && $stable(two_stop) && $stable(char_bits))); // R10

endmodule

bind async_fmt_baud async_fmt_baud_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .mode_we(mode_we), .frame_we(frame_we),
  .tc_lo_we(tc_lo_we), .tc_hi_we(tc_hi_we), .wr_data(wr_data),
  .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
  .char_bits(char_bits), .baud_tick(baud_tick)
);

// File: tb/async_fmt_baud_tb_top.sv
module async_fmt_baud_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0, frame_we = 1'b0, tc_lo_we = 1'b0, tc_hi_we = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       par_en, par_even, two_stop, baud_tick;
  logic [3:0] char_bits;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int wr_cyc = 0;
  logic [7:0] cur_mode = 8'h04;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_fmt_baud dut_i (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .frame_we(frame_we),
    .tc_lo_we(tc_lo_we), .tc_hi_we(tc_hi_we), .wr_data(wr_data),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .char_bits(char_bits), .baud_tick(baud_tick)
  );

  function automatic int exp_len(input logic [7:0] fb);
    case (fb[6:5])
      2'b00:   return 5;
      2'b01:   return 7;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int exp_period(input int tc, input logic [7:0] mb);
    int p;
    case (mb[7:6])
      2'b00:   p = 1;
      2'b01:   p = 16;
      2'b10:   p = 32;
      default: p = 64;
    endcase
    return (tc + 2) * p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel: 0 line-mode, 1 char-format, 2 tc low, 3 tc high
  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_data  = d;
    mode_we  = (sel == 0);
    frame_we = (sel == 1);
    tc_lo_we = (sel == 2);
    tc_hi_we = (sel == 3);
    @(posedge clk);
    @(negedge clk);
    mode_we = 1'b0; frame_we = 1'b0; tc_lo_we = 1'b0; tc_hi_we = 1'b0;
    if (sel != 1) wr_cyc = cyc;
    if (sel == 0) cur_mode = d;
  endtask

  // returns the cycle count at the falling edge where the tick is seen
  task automatic wait_tick(output int at);
    int n;
    n = 0;
    @(negedge clk);
    while (!baud_tick && n < 20000) begin
      @(negedge clk);
      n++;
    end
    at = cyc;
  endtask

  task automatic fmt_check(input logic [7:0] mb, input logic [7:0] fb);
    check(par_en == mb[0], "R2 par_en", par_en, mb[0]);
    check(par_even == mb[1], "R2 par_even", par_even, mb[1]);
    check(two_stop == (mb[3:2] == 2'b11), "R3 two_stop", two_stop, mb[3:2] == 2'b11);
    check(char_bits == exp_len(fb), "R4 char_bits", char_bits, exp_len(fb));
  endtask

  task automatic period_check(input int tc, input string req);
    int t1, t2, e;
    e = exp_period(tc, cur_mode);
    wait_tick(t1);
    check(t1 - wr_cyc == e, {req, " R7 first tick"}, t1 - wr_cyc, e);
    @(negedge clk);
    check(baud_tick == 1'b0, "R8 single cycle", baud_tick, 0);
    wait_tick(t2);
    check(t2 - t1 == e, {req, " period"}, t2 - t1, e);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed, t1, t2, tc, e;
    logic [7:0] mb, fb;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    fmt_check(8'h04, 8'h00);
    check(par_en == 0 && two_stop == 0 && char_bits == 5, "R1 reset format", char_bits, 5);
    wait_tick(t1);
    wait_tick(t2);
    check(t2 - t1 == 2, "R1 reset period", t2 - t1, 2);

    // R4 all length codes, R10 immediate update
    for (int c = 0; c < 4; c++) begin
      fb = 8'(c << 5) | 8'h9f;
      wr(1, fb);
      check(char_bits == exp_len(fb), "R4 R10 len code", char_bits, exp_len(fb));
    end

    // R3 all stop codes with R2 parity combos
    for (int c = 0; c < 4; c++) begin
      mb = 8'(c << 2) | 8'(c);
      wr(0, mb);
      fmt_check(mb, fb);
    end

    // R5 x1 with both bytes, high byte order
    wr(3, 8'h01); wr(2, 8'h02); wr(0, 8'h00);
    period_check(258, "R5 tc=0x0102");
    // R6 /16 on same tc
    wr(0, 8'h40);
    period_check(258, "R6 x16");
    // R6 /32, /64 with tc 0
    wr(3, 8'h00); wr(2, 8'h00); wr(0, 8'h80);
    period_check(0, "R6 x32");
    wr(0, 8'hc0);
    period_check(0, "R6 x64");

    // R9 char-format write does not disturb phase
    wr(2, 8'd10); wr(0, 8'h40);
    repeat (37) @(negedge clk);
    wr(1, 8'h60);
    e = exp_period(10, cur_mode);
    wait_tick(t1);
    check(t1 - wr_cyc == e, "R9 phase kept", t1 - wr_cyc, e);
    check(char_bits == 8, "R9 R4 len", char_bits, 8);

    // R7 timing write in mid-period restarts
    wr(2, 8'd20);
    repeat (100) @(negedge clk);
    wr(2, 8'd5);
    period_check(5, "R7 restart");

    // random mix
    for (int i = 0; i < 16; i++) begin
      tc = $urandom % 40;
      mb = 8'($urandom);
      fb = 8'($urandom);
      wr(1, fb);
      wr(3, 8'h00);
      wr(2, 8'(tc));
      wr(0, mb);
      fmt_check(mb, fb);
      period_check(tc, "R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule